// File: doc/BRIEF.md
# Serial Lane Character Deserializer

This block turns serial data lanes into 10-bit parallel characters. All lanes of a channel share one forwarded reference clock. A bit-rate enable pulses once for each serial bit, which is ten times the character clock. On every enable pulse, each lane shifts in one bit, least significant bit first. The level of the forwarded clock is sampled on the same pulses. A falling edge of that sampled level marks the first bit of a new character.

At each such boundary, the ten bits gathered since the previous boundary are copied to a parallel output register for all lanes at once. A one-cycle valid strobe follows. The first boundary after reset only aligns the block. A boundary that closes a word of any length other than ten bits raises a sticky framing-error flag and drops that word. The default build has three lanes, one each for red, green and blue.

Top module: `lane_char_deser`

## Requirements
- R1: While reset is high and in the cycle after it is released, `char_valid` is 0, `frame_err` is 0 and `char_data` is all zeros.
- R2: Within each character, the first serial bit received lands in bit 0 of that lane's field, and the tenth lands in bit 9.
- R3: A boundary is an enable pulse on which `fwd_lvl` is 0 while the level captured on the previous enable pulse was 1. The bit taken on that pulse is bit 0 of the new character. Changes of `fwd_lvl` in cycles without an enable have no effect.
- R4: For a boundary that closes exactly ten bits, `char_valid` is 1 for exactly the one cycle after the boundary's clock edge. In that cycle, `char_data` holds the closed characters.
- R5: Bits are taken only on cycles where `bit_en` is 1. Idle cycles between bits do not change the assembled character.
- R6: The first boundary after reset produces neither a valid strobe nor a framing error.
- R7: A later boundary that closes a count other than ten bits (fewer, or more) sets `frame_err`. It raises no valid strobe, leaves `char_data` unchanged, and the next ten-bit character is delivered normally.
- R8: `frame_err` stays 1 until reset, and reset clears it.
- R9: Lane i occupies bits [10i+9:10i] of `char_data`. Every lane is framed by the same boundaries.
- R10: `char_data` changes only in a cycle where `char_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One pulse per serial bit |
| ser_in | input | LANES (3) | Serial bit of each lane, sampled on `bit_en` |
| fwd_lvl | input | 1 | Level of the forwarded reference clock, sampled on `bit_en` |
| char_data | output | LANES*CHAR_W (30) | Parallel characters, lane i in bits [10i+9:10i] |
| char_valid | output | 1 | One-cycle strobe for a newly delivered character |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The boundary detection and the shift of a new bit fall in the same cycle. The enable that carries a falling edge both closes the old word and supplies bit 0 of the next word. The bench checks that the delivered word excludes that bit and that the following word starts with it.

A second coincidence is a boundary that arrives after a 6-bit or 13-bit run. In that cycle, the error set and the withheld load must happen together. The bench judges this by `frame_err` rising while `char_valid` stays low and `char_data` keeps the previous word.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  // Saturating bit counter step: stops one above the character width so that
  // an overlong run stays distinguishable from a complete character.
  function automatic int unsigned sat_inc(int unsigned cur, int unsigned lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

  // Width of a counter able to hold 0 .. width+1.
  function automatic int unsigned cnt_bits(int unsigned width);
    return $clog2(width + 2);
  endfunction
endpackage

// File: rtl/lcd_edge.sv
module lcd_edge (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic fwd_lvl,
  output logic boundary
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst)         prev_q <= 1'b0;
    else if (bit_en) prev_q <= fwd_lvl;
  end

  assign boundary = bit_en & prev_q & ~fwd_lvl;
endmodule

// File: rtl/lcd_framer.sv
module lcd_framer #(
  parameter int unsigned CHAR_W = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic boundary,
  output logic load,
  output logic err_set,
  output logic frame_err
);
  localparam int unsigned CNT_W = lcd_pkg::cnt_bits(CHAR_W);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CHAR_W);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             synced_q;
  logic             err_q;

  assign load      = boundary & synced_q & (cnt_q == FULL);
  assign err_set   = boundary & synced_q & (cnt_q != FULL);
  assign frame_err = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      synced_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (bit_en)
        cnt_q <= boundary ? ONE
                          : CNT_W'(lcd_pkg::sat_inc(int'(cnt_q), CHAR_W + 1));
      if (boundary) synced_q <= 1'b1;
      if (err_set)  err_q    <= 1'b1;
    end
  end

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(cnt_q));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
endmodule

// File: rtl/lcd_lane_shift.sv
module lcd_lane_shift #(
  parameter int unsigned CHAR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              din,
  output logic [CHAR_W-1:0] word
);
  logic [CHAR_W-1:0] sh_q;

  // LSB-first: newest bit enters at the top, oldest drifts toward bit 0
  always_ff @(posedge clk) begin
    if (rst)         sh_q <= '0;
    else if (bit_en) sh_q <= {din, sh_q[CHAR_W-1:1]};
  end

  assign word = sh_q;
endmodule

// File: rtl/lcd_out_reg.sv
module lcd_out_reg #(
  parameter int unsigned DW = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q,
  output logic          valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      valid <= 1'b0;
    end else begin
      valid <= load;
      if (load) q <= d;
    end
  end

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |-> $stable(q));
endmodule

// File: rtl/lane_char_deser.sv
module lane_char_deser #(
  parameter int unsigned CHAR_W = 10,
  parameter int unsigned LANES  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bit_en,
  input  logic [LANES-1:0]          ser_in,
  input  logic                      fwd_lvl,
  output logic [LANES*CHAR_W-1:0]   char_data,
  output logic                      char_valid,
  output logic                      frame_err
);
  localparam int unsigned DW = LANES * CHAR_W;

  logic          boundary;
  logic          load;
  logic          err_set;
  logic [DW-1:0] lane_words;

  lcd_edge u_edge (
    .clk(clk), .rst(rst), .bit_en(bit_en), .fwd_lvl(fwd_lvl),
    .boundary(boundary)
  );

  lcd_framer #(.CHAR_W(CHAR_W)) u_framer (
    .clk(clk), .rst(rst), .bit_en(bit_en), .boundary(boundary),
    .load(load), .err_set(err_set), .frame_err(frame_err)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lcd_lane_shift #(.CHAR_W(CHAR_W)) u_shift (
      .clk(clk), .rst(rst), .bit_en(bit_en), .din(ser_in[i]),
      .word(lane_words[i*CHAR_W +: CHAR_W])
    );
  end

  lcd_out_reg #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .load(load), .d(lane_words),
    .q(char_data), .valid(char_valid)
  );

  // R7
  err_blocks_valid_chk: assert property (@(posedge clk) disable iff (rst)
    err_set |=> !char_valid);

  // R7
  err_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_err) |-> $stable(char_data));
endmodule

// File: tb/lane_char_deser_tb_top.sv
`timescale 1ns/1ps
module lane_char_deser_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        bit_en;
  logic [2:0]  ser_in;
  logic        fwd_lvl;
  logic [29:0] char_data;
  logic        char_valid;
  logic        frame_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lane_char_deser #(.CHAR_W(10), .LANES(3)) dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .ser_in(ser_in), .fwd_lvl(fwd_lvl),
    .char_data(char_data), .char_valid(char_valid), .frame_err(frame_err)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives n bits; forwarded level low for the first half, high for the rest.
  task automatic send_bits(input logic [9:0] w0, input logic [9:0] w1,
                           input logic [9:0] w2, input int n, input bit gap,
                           output logic vf, output logic [29:0] df,
                           output logic vx);
    vx = 1'b0; vf = 1'b0; df = '0;
    for (int b = 0; b < n; b++) begin
      automatic int k = b % 10;
      bit_en  = 1'b1;
      ser_in  = {w2[k], w1[k], w0[k]};
      fwd_lvl = (b >= n / 2);
      @(negedge clk);
      bit_en = 1'b0;
      if (b == 0) begin vf = char_valid; df = char_data; end
      else if (char_valid) vx = 1'b1;
      if (gap) begin
        @(negedge clk);
        if (char_valid) vx = 1'b1;
      end
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; bit_en = 1'b0; ser_in = '0; fwd_lvl = 1'b0;
    repeat (3) @(negedge clk);
    check(char_valid == 0 && frame_err == 0 && char_data == 0, "R1 in reset",
          {char_valid, frame_err, char_data}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(char_valid == 0 && frame_err == 0 && char_data == 0, "R1 after release",
          {char_valid, frame_err, char_data}, 32'h0);
  endtask

  logic vf, vx;
  logic [29:0] df;

  task automatic t_stream();
    send_bits(10'h2AA, 10'h155, 10'h3FF, 10, 0, vf, df, vx);
    check(!vf, "R6 preamble", vf, 0);
    send_bits(10'h001, 10'h1A2, 10'h3C5, 10, 0, vf, df, vx);
    check(!vf, "R6 first boundary no valid", vf, 0);
    check(!frame_err, "R6 first boundary no error", frame_err, 0);
    send_bits(10'h200, 10'h0F0, 10'h333, 10, 0, vf, df, vx);
    check(vf, "R4 valid after boundary", vf, 1);
    check(df == {10'h3C5, 10'h1A2, 10'h001}, "R9 lane fields",
          df, {10'h3C5, 10'h1A2, 10'h001});
    check(df[9:0] == 10'h001, "R2 first bit in bit 0", df[9:0], 10'h001);
    check(!vx, "R4 single pulse", vx, 0);
    send_bits(10'h0AB, 10'h3E1, 10'h10F, 10, 1, vf, df, vx);
    check(vf && df == {10'h333, 10'h0F0, 10'h200}, "R2 msb word",
          df, {10'h333, 10'h0F0, 10'h200});
    check(!vx, "R4 no extra pulse with gaps", vx, 0);
    repeat (6) @(negedge clk);
    check(!char_valid && char_data == {10'h333, 10'h0F0, 10'h200}, "R10 hold",
          char_data, {10'h333, 10'h0F0, 10'h200});
    send_bits(10'h155, 10'h0C3, 10'h2D2, 10, 0, vf, df, vx);
    check(vf && df == {10'h10F, 10'h3E1, 10'h0AB}, "R5 gapped word",
          df, {10'h10F, 10'h3E1, 10'h0AB});
    check(!frame_err, "R5 no error", frame_err, 0);
  endtask

  task automatic t_idle_edge();
    fwd_lvl = 1'b0;
    repeat (4) @(negedge clk);
    fwd_lvl = 1'b1;
    repeat (2) @(negedge clk);
    check(!char_valid, "R3 idle edge no valid", char_valid, 0);
    send_bits(10'h3A5, 10'h05A, 10'h1E7, 10, 0, vf, df, vx);
    check(vf && df == {10'h2D2, 10'h0C3, 10'h155}, "R3 idle edge ignored",
          df, {10'h2D2, 10'h0C3, 10'h155});
    check(!frame_err, "R3 no error", frame_err, 0);
  endtask

  task automatic t_short();
    send_bits(10'h011, 10'h022, 10'h033, 6, 0, vf, df, vx);
    check(vf && df == {10'h1E7, 10'h05A, 10'h3A5}, "R4 word before short",
          df, {10'h1E7, 10'h05A, 10'h3A5});
    send_bits(10'h3C3, 10'h2B4, 10'h1D2, 10, 0, vf, df, vx);
    check(!vf, "R7 short no valid", vf, 0);
    check(frame_err, "R7 short sets error", frame_err, 1);
    check(char_data == {10'h1E7, 10'h05A, 10'h3A5}, "R7 data kept",
          char_data, {10'h1E7, 10'h05A, 10'h3A5});
    send_bits(10'h0FF, 10'h300, 10'h0C0, 10, 0, vf, df, vx);
    check(vf && df == {10'h1D2, 10'h2B4, 10'h3C3}, "R7 resume after error",
          df, {10'h1D2, 10'h2B4, 10'h3C3});
    check(frame_err, "R8 error sticky", frame_err, 1);
    do_reset();
    check(!frame_err, "R8 reset clears", frame_err, 0);
  endtask

  task automatic t_overrun();
    send_bits(10'h000, 10'h000, 10'h000, 10, 0, vf, df, vx);
    send_bits(10'h123, 10'h234, 10'h345, 10, 0, vf, df, vx);
    send_bits(10'h0AA, 10'h0BB, 10'h0CC, 13, 0, vf, df, vx);
    check(vf && df == {10'h345, 10'h234, 10'h123}, "R9 before overrun",
          df, {10'h345, 10'h234, 10'h123});
    send_bits(10'h111, 10'h222, 10'h333, 10, 0, vf, df, vx);
    check(!vf, "R7 overrun no valid", vf, 0);
    check(frame_err, "R7 overrun sets error", frame_err, 1);
  endtask

  initial begin
    do_reset();
    t_stream();
    t_idle_edge();
    t_short();
    t_overrun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule